// File: doc/BRIEF.md
# Pipeline Stage Flow Controller

This block governs the flow of one out-of-order pipeline stage. It decides each cycle whether the stage is passing groups through, holding back its upstream neighbour, replaying parked groups, or cleaning up after a squash from the commit side. Groups that arrive while the stage is held are parked in a small skid buffer. They come back out one per cycle, in arrival order, once the hold is lifted. Upstream is told to stall until that buffer has drained completely.

Five states are named: IDLE (0, after reset), RUN (1), BLOCK (2), UNBLK (3) and SQUASH (4). The transitions are as follows:
- IDLE and RUN both go to BLOCK on a downstream stall. Otherwise they go to SQUASH on either squash flag, and otherwise to RUN.
- BLOCK goes to SQUASH on either squash flag. Otherwise it goes to UNBLK once the downstream stall and the issue-queue-full flag are both clear.
- UNBLK goes to BLOCK on a downstream stall and to SQUASH on a squash flag. Otherwise it goes to RUN when the buffer is empty after the cycle.
- SQUASH goes to RUN in the first cycle in which both squash flags are clear.

The issue queue receives a start strobe when squashing begins, a continue strobe in each cycle the squash persists, and a stop strobe when it ends. Three counters report the number of cycles spent blocked, unblocking and squashing. A sticky flag reports a push into a full skid buffer. Only the group size is carried, because instruction payloads are outside this block.

Top module: `stage_flow_ctrl`

## Requirements
- R1: Reset puts state_o at IDLE (0) with up_stall, all strobes, ovf_err and all counters at 0. State encodings: IDLE 0, RUN 1, BLOCK 2, UNBLK 3, SQUASH 4. IDLE responds to the inputs exactly like RUN.
- R2: In RUN or IDLE, dn_stall moves the state to BLOCK at the next edge and pushes the current group if up_valid is high. dn_stall takes priority over any squash flag.
- R3: In RUN or IDLE, with dn_stall low, either dn_squash or dn_rob_squash moves the state to SQUASH. sq_start is high in that same cycle.
- R4: In BLOCK, up_stall is high every cycle, and each group presented with up_valid is pushed in arrival order.
- R5: BLOCK moves to UNBLK only when dn_stall and iq_full are both low. Either squash flag in BLOCK wins over that, moves the state to SQUASH with sq_start, and discards the skid buffer contents.
- R6: In UNBLK, when neither dn_stall nor a squash flag is present, one buffered group is popped per cycle. It appears on rep_valid/rep_size in the same cycle, oldest first. up_stall stays high unless the buffer will be empty after the pop. The state becomes RUN once the buffer is empty and no new group arrives.
- R7: In UNBLK, dn_stall returns the state to BLOCK without a pop. Otherwise a squash flag moves it to SQUASH with sq_start, without a pop, and discards the buffer.
- R8: In SQUASH, sq_cont is high in every cycle with either squash flag set. In the first cycle with both flags clear, sq_stop is high and the state moves to RUN. dn_stall has no effect there. At most one strobe is high in any cycle.
- R9: A push into a full skid buffer (SKID_DEPTH entries) with no pop in the same cycle drops the group and sets ovf_err. ovf_err stays set until reset.
- R10: cnt_blocked, cnt_unblock and cnt_squash each add one for every clock edge at which the state is BLOCK, UNBLK or SQUASH respectively. Each holds at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream group present this cycle |
| up_size | input | GRP_W | Size of the upstream group |
| dn_stall | input | 1 | Downstream stall request |
| dn_squash | input | 1 | Downstream squash request |
| dn_rob_squash | input | 1 | Reorder buffer still squashing |
| iq_full | input | 1 | Issue queue has no free entry |
| up_stall | output | 1 | Stall request to the upstream stage |
| state_o | output | 3 | Current state encoding |
| rep_valid | output | 1 | Replay group popped from the skid buffer |
| rep_size | output | GRP_W | Size of the replayed group |
| sq_start | output | 1 | Squash begins this cycle |
| sq_cont | output | 1 | Squash continues this cycle |
| sq_stop | output | 1 | Squash ends this cycle |
| ovf_err | output | 1 | Sticky skid buffer overflow |
| cnt_blocked | output | CNT_W | Cycles spent in BLOCK, saturating |
| cnt_unblock | output | CNT_W | Cycles spent in UNBLK, saturating |
| cnt_squash | output | CNT_W | Cycles spent in SQUASH, saturating |

## Verification
A wrong state register is visible on state_o one edge after the offending input, and in the same cycle on up_stall and the squash strobes, because these outputs decode the state together with the present inputs. A wrong skid buffer, such as a missed flush, a lost push or an out-of-order pop, stays hidden until the next UNBLK phase. Only then does rep_size or up_stall differ, which may be many cycles after the fault. The stimulus therefore always drains the buffer soon after filling or flushing it. A miscounted cycle appears only in the counter values, so the counters are checked against totals tallied over a known run.

// File: rtl/stage_flow_pkg.sv
package stage_flow_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RUN    = 3'd1,
        ST_BLOCK  = 3'd2,
        ST_UNBLK  = 3'd3,
        ST_SQUASH = 3'd4
    } flow_state_e;

    localparam int NUM_PHASE_CNT = 3;

endpackage

// File: rtl/stage_skid_fifo.sv
module stage_skid_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             full, do_push;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full     = (cnt_q == CNT_W'(DEPTH));
    assign do_push  = push && (!full || pop);
    assign overflow = push && full && !pop && !flush;
    assign head     = mem[rd_ptr];
    assign count    = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)     rd_ptr <= ptr_next(rd_ptr);
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && !flush && do_push) mem[wr_ptr] <= push_data;
    end

    // R9: occupancy never exceeds the configured depth
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    // R6: a pop is only ever requested on a non-empty buffer
    a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0));

endmodule

// File: rtl/stage_sat_cnt.sv
module stage_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (inc && (q != '1))
            q <= q + W'(1);
    end

    // R10: an all-ones counter never wraps back
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q) == '1) |-> (q == '1));

endmodule

// File: rtl/stage_flow_ctrl.sv
module stage_flow_ctrl
    import stage_flow_pkg::*;
#(
    parameter int SKID_DEPTH = 4,
    parameter int GRP_W      = 3,
    parameter int CNT_W      = 32,
    localparam int FC_W      = $clog2(SKID_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_valid,
    input  logic [GRP_W-1:0] up_size,
    input  logic             dn_stall,
    input  logic             dn_squash,
    input  logic             dn_rob_squash,
    input  logic             iq_full,
    output logic             up_stall,
    output logic [2:0]       state_o,
    output logic             rep_valid,
    output logic [GRP_W-1:0] rep_size,
    output logic             sq_start,
    output logic             sq_cont,
    output logic             sq_stop,
    output logic             ovf_err,
    output logic [CNT_W-1:0] cnt_blocked,
    output logic [CNT_W-1:0] cnt_unblock,
    output logic [CNT_W-1:0] cnt_squash
);

    flow_state_e      state_q, state_d;
    logic             any_sq;
    logic             f_push, f_pop, f_flush, f_ovf;
    logic [GRP_W-1:0] f_head;
    logic [FC_W-1:0]  f_cnt;
    logic             ovf_q;
    logic [CNT_W-1:0] phase_cnt [NUM_PHASE_CNT];

    assign any_sq = dn_squash || dn_rob_squash;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_RUN: begin
                if (dn_stall)    state_d = ST_BLOCK;
                else if (any_sq) state_d = ST_SQUASH;
                else             state_d = ST_RUN;
            end
            ST_BLOCK: begin
                if (any_sq)                     state_d = ST_SQUASH;
                else if (!dn_stall && !iq_full) state_d = ST_UNBLK;
            end
            ST_UNBLK: begin
                if (dn_stall)                                 state_d = ST_BLOCK;
                else if (any_sq)                              state_d = ST_SQUASH;
                else if (f_cnt <= FC_W'(1) && !up_valid)      state_d = ST_RUN;
            end
            ST_SQUASH: begin
                if (!any_sq) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output and buffer-control decode
    always_comb begin
        f_push   = 1'b0;
        f_pop    = 1'b0;
        f_flush  = 1'b0;
        up_stall = 1'b0;
        sq_start = 1'b0;
        sq_cont  = 1'b0;
        sq_stop  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_RUN: begin
                f_push   = dn_stall && up_valid;
                sq_start = !dn_stall && any_sq;
            end
            ST_BLOCK: begin
                up_stall = 1'b1;
                f_push   = !any_sq && up_valid;
                f_flush  = any_sq;
                sq_start = any_sq;
            end
            ST_UNBLK: begin
                f_push   = up_valid && (dn_stall || !any_sq);
                f_pop    = !dn_stall && !any_sq && (f_cnt != '0);
                f_flush  = !dn_stall && any_sq;
                sq_start = !dn_stall && any_sq;
                up_stall = (f_cnt > FC_W'(1)) || ((f_cnt == FC_W'(1)) && !f_pop);
            end
            ST_SQUASH: begin
                sq_cont = any_sq;
                sq_stop = !any_sq;
            end
            default: ;
        endcase
    end

    assign rep_valid = f_pop;
    assign rep_size  = f_head;
    assign state_o   = state_q;
    assign ovf_err   = ovf_q;

    stage_skid_fifo #(
        .DEPTH (SKID_DEPTH),
        .W     (GRP_W)
    ) u_skid (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (f_flush),
        .push      (f_push),
        .push_data (up_size),
        .pop       (f_pop),
        .head      (f_head),
        .count     (f_cnt),
        .overflow  (f_ovf)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)     ovf_q <= 1'b0;
        else if (f_ovf) ovf_q <= 1'b1;
    end

    localparam flow_state_e PHASE_ST [NUM_PHASE_CNT] = '{ST_BLOCK, ST_UNBLK, ST_SQUASH};

    for (genvar g = 0; g < NUM_PHASE_CNT; g++) begin : g_phase
        stage_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (state_q == PHASE_ST[g]),
            .q     (phase_cnt[g])
        );
    end

    assign cnt_blocked = phase_cnt[0];
    assign cnt_unblock = phase_cnt[1];
    assign cnt_squash  = phase_cnt[2];

    // R2: a downstream stall in RUN leads to an upstream stall next cycle
    a_r2_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && dn_stall) |=> up_stall);

    // R3: a squash flag in RUN without stall leads to SQUASH
    a_r3_enter_squash: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !dn_stall && any_sq) |=> (state_q == ST_SQUASH));

    // R5: BLOCK never leaves for UNBLK while stall or queue-full persists
    a_r5_unblock_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCK && (dn_stall || iq_full)) |=> (state_q != ST_UNBLK));

    // R6: RUN is reached from UNBLK only with an empty skid buffer
    a_r6_drained: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_UNBLK && state_q == ST_RUN) |-> (f_cnt == '0));

    // R8: squashing persists while any squash flag is held
    a_r8_hold_squash: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SQUASH && any_sq) |=> (state_q == ST_SQUASH));

    // R8: at most one issue-queue strobe per cycle
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sq_start, sq_cont, sq_stop}));

    // R9: the overflow flag is sticky
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovf_q) |-> ovf_q);

endmodule

// File: tb/tb_stage_flow_ctrl.sv
`timescale 1ns/1ps
module tb_stage_flow_ctrl;

    localparam int GW = 3;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_valid = 1'b0;
    logic [GW-1:0] up_size = '0;
    logic          dn_stall = 1'b0, dn_squash = 1'b0, dn_rob_squash = 1'b0, iq_full = 1'b0;
    logic          up_stall, rep_valid, sq_start, sq_cont, sq_stop, ovf_err;
    logic [2:0]    state_o;
    logic [GW-1:0] rep_size;
    logic [CW-1:0] cnt_blocked, cnt_unblock, cnt_squash;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    stage_flow_ctrl #(.SKID_DEPTH(4), .GRP_W(GW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_size(up_size),
        .dn_stall(dn_stall), .dn_squash(dn_squash), .dn_rob_squash(dn_rob_squash),
        .iq_full(iq_full), .up_stall(up_stall), .state_o(state_o),
        .rep_valid(rep_valid), .rep_size(rep_size), .sq_start(sq_start),
        .sq_cont(sq_cont), .sq_stop(sq_stop), .ovf_err(ovf_err),
        .cnt_blocked(cnt_blocked), .cnt_unblock(cnt_unblock), .cnt_squash(cnt_squash)
    );

    // Vector: uv, us[3], st, sq, rb, iqf | exp up_stall, rep_valid, rep_size[3], {start,cont,stop}, next state
    localparam int NV = 26;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,3'd0,3'b000,3'd1},
        {1'b1,3'd2,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,3'd0,3'b000,3'd2},
        {1'b1,3'd5,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,3'd0,3'b000,3'd2},
        {1'b0,3'd0,1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0,3'd0,3'b000,3'd2},
        {1'b1,3'd3,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,3'd0,3'b000,3'd3},
        {1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,3'd2,3'b000,3'd3},
        {1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,3'd5,3'b000,3'd3},
        {1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,3'd3,3'b000,3'd1},
        {1'b0,3'd0,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,3'd0,3'b100,3'd4},
        {1'b0,3'd0,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,3'd0,3'b010,3'd4},
        {1'b0,3'd0,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,3'd0,3'b010,3'd4},
        {1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,3'd0,3'b001,3'd1},
        {1'b1,3'd6,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,3'd0,3'b000,3'd2},
        {1'b0,3'd0,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,3'd0,3'b100,3'd4},
        {1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,3'd0,3'b001,3'd1},
        {1'b0,3'd0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,3'd0,3'b000,3'd2},
        {1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,3'd0,3'b000,3'd3},
        {1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,3'd0,3'b000,3'd1},
        {1'b1,3'd1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,3'd0,3'b000,3'd2},
        {1'b1,3'd4,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,3'd0,3'b000,3'd3},
        {1'b0,3'd0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,3'd0,3'b000,3'd2},
        {1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,3'd0,3'b000,3'd3},
        {1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,3'd1,3'b000,3'd3},
        {1'b1,3'd7,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,3'd4,3'b000,3'd3},
        {1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,3'd7,3'b000,3'd1},
        {1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,3'd0,3'b000,3'd1}
    };

    function automatic string req_of(input int s);
        if (s == 0)       return "R1";
        else if (s <= 2)  return "R2";
        else if (s <= 4)  return "R5";
        else if (s <= 7)  return "R6";
        else if (s == 8)  return "R3";
        else if (s <= 11) return "R8";
        else if (s == 12) return "R2";
        else if (s == 13) return "R5";
        else if (s == 14) return "R8";
        else if (s <= 17) return "R5";
        else if (s <= 19) return "R4";
        else if (s <= 21) return "R7";
        else              return "R6";
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_in(input logic uv, input int us, input logic st,
                          input logic sq, input logic rb, input logic iqf);
        up_valid = uv; up_size = GW'(us); dn_stall = st;
        dn_squash = sq; dn_rob_squash = rb; iq_full = iqf;
    endtask

    task automatic cyc(input logic uv, input int us, input logic st,
                       input logic sq, input logic rb, input logic iqf);
        @(negedge clk);
        set_in(uv, us, st, sq, rb, iqf);
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        set_in(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(state_o == 3'd0, "R1", "reset state", state_o, 0);
        chk(!up_stall && !sq_start && !sq_cont && !sq_stop && !rep_valid, "R1", "reset outputs", 0, 0);
        chk(!ovf_err, "R1", "reset ovf", ovf_err, 0);
        chk(cnt_blocked == 0 && cnt_unblock == 0 && cnt_squash == 0, "R1", "reset counters",
            cnt_blocked + cnt_unblock + cnt_squash, 0);
        rst_n = 1'b1;

        // Table walk: drive at negedge, check combinational outputs mid-low, state after edge
        for (int i = 0; i < NV; i++) begin
            logic [18:0] v;
            v = VEC[i];
            @(negedge clk);
            set_in(v[18], int'(v[17:15]), v[14], v[13], v[12], v[11]);
            #2;
            chk(up_stall == v[10], req_of(i), $sformatf("step %0d up_stall", i), up_stall, v[10]);
            chk(rep_valid == v[9], req_of(i), $sformatf("step %0d rep_valid", i), rep_valid, v[9]);
            if (v[9])
                chk(rep_size == v[8:6], req_of(i), $sformatf("step %0d rep_size", i), rep_size, v[8:6]);
            chk({sq_start, sq_cont, sq_stop} == v[5:3], req_of(i), $sformatf("step %0d strobes", i),
                {sq_start, sq_cont, sq_stop}, v[5:3]);
            @(posedge clk);
            #1;
            chk(state_o == v[2:0], req_of(i), $sformatf("step %0d next state", i), state_o, v[2:0]);
        end

        // R10: cycle totals over the table run
        @(negedge clk);
        chk(cnt_blocked == 7, "R10", "blocked cycles", cnt_blocked, 7);
        chk(cnt_unblock == 8, "R10", "unblock cycles", cnt_unblock, 8);
        chk(cnt_squash == 4, "R10", "squash cycles", cnt_squash, 4);

        // R9: overflow of a 4-deep skid buffer
        do_reset();
        cyc(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1, 1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 2, 1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 3, 1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 4, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(!ovf_err, "R9", "no overflow at exactly full", ovf_err, 0);
        cyc(1'b1, 5, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(ovf_err, "R9", "overflow on push into full", ovf_err, 1);
        cyc(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(state_o == 3'd3, "R5", "unblock after clear", state_o, 3);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            set_in(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
            #2;
            chk(rep_valid && rep_size == GW'(k), "R6", "drain order after overflow", rep_size, k);
            @(posedge clk);
        end
        #1;
        chk(state_o == 3'd1, "R6", "run after drain, dropped group absent", state_o, 1);
        chk(ovf_err, "R9", "overflow sticky", ovf_err, 1);

        // R7: squash during unblocking discards the buffer
        do_reset();
        cyc(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 2, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(!ovf_err, "R1", "reset clears overflow", ovf_err, 0);
        cyc(1'b1, 3, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        set_in(1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        #2;
        chk(!rep_valid && sq_start, "R7", "squash in unblock: no pop, start", rep_valid, 0);
        @(posedge clk);
        #1;
        chk(state_o == 3'd4, "R7", "squash from unblock", state_o, 4);
        cyc(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        set_in(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        #2;
        chk(!rep_valid, "R7", "buffer discarded by squash", rep_valid, 0);
        @(posedge clk);
        #1;
        chk(state_o == 3'd1, "R7", "run after empty unblock", state_o, 1);

        // R10: saturation of the blocked counter at 255
        do_reset();
        cyc(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 300; k++) cyc(1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(cnt_blocked == 8'd255, "R10", "blocked counter saturates", cnt_blocked, 255);
        chk(cnt_squash == 0, "R10", "squash counter untouched", cnt_squash, 0);

        finish_run();
    end

endmodule